// File: doc/BRIEF.md
# CAN Controller Control and Interrupt Register Front End

This block is the byte-wide register slice that sits between a host read/write port and a CAN protocol engine. It holds the operating-mode register and turns host writes to a command location into single-cycle strobes for the engine. It assembles a read-only status word from live level inputs plus one sticky overrun flag. It also collects event pulses from the engine into a latched cause register. An enable register masks that cause register down to a single registered interrupt line.

The host reads the cause register to learn why the interrupt fired. That read clears the latched causes, except that the receive cause stays up while the engine still reports queued frames. Commands that start a transmission are refused while the controller is held in its reset mode. The bit-level protocol engine, the receive frame storage and the bit timing logic lie outside this block.

Top module: `canctl_csr`

## Requirements
- R1: After a synchronous reset the mode register reads 0x01 (reset mode active), the enable and cause registers read 0, `irq` is 0, every command strobe is 0 and `bus_rdata` is 0.
- R2: A write to offset 0x00 loads bits 4:0 into the mode register: bit 0 reset mode, bit 1 listen-only, bit 2 self-test, bit 3 single-filter select, bit 4 sleep. Bits 7:5 are dropped. The value reads back at 0x00 and drives the five mode outputs from the next cycle.
- R3: A write to offset 0x01 raises, for exactly the one cycle after the write edge, the strobe of each set data bit. The mapping is bit 0 transmit request, bit 1 abort, bit 2 receive release, bit 3 clear overrun, bit 4 self-receive. A read of 0x01 returns 0.
- R4: While mode bit 0 is 1 at the write edge, command bits 0 (transmit request) and 4 (self-receive) produce no strobe. The other three command bits still strobe.
- R5: A read of offset 0x02 returns a status word with these bits: bit 0 is set when `rx_msg_count` is nonzero, and bit 1 is the sticky overrun flag. Bit 2 is transmit buffer free, bit 3 transmission complete, bit 4 receiving and bit 5 transmitting. Bit 6 is the error limit, bit 7 bus-off and bit 8 partial frame. Bits above 8 read 0.
- R6: An `ev_overrun` pulse sets the sticky overrun flag. A command write with bit 3 set clears it, unless `ev_overrun` is high in the same cycle, in which case the flag stays set.
- R7: Each event pulse sets its bit in the cause register at offset 0x03. The mapping is bit 0 frame received, bit 1 transmit done, bit 2 error warning, bit 3 overrun, bit 5 error passive, bit 6 arbitration lost and bit 7 bus error. Bit 4 always reads 0.
- R8: A read of 0x03 returns the cause value held before the read and then clears every latched bit. Bit 0 is the exception and stays set while `rx_msg_count` is nonzero. An event arriving in the same cycle as the read is latched for the next read.
- R9: Offset 0x04 is a read/write enable register with the cause layout. Bit 4 is not stored and reads 0.
- R10: `irq` is the registered OR of the cause bits ANDed with the enable bits. A write to the enable register or a newly latched cause shows on `irq` in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | RD_W | Registered read data, valid the cycle after `bus_rd` |
| rx_msg_count | input | CNT_W | Frames waiting in receive storage |
| st_tx_buf_free | input | 1 | Transmit buffer may be written |
| st_tx_done_flag | input | 1 | Last transmission completed |
| st_receiving | input | 1 | Engine receiving a frame |
| st_transmitting | input | 1 | Engine transmitting a frame |
| st_err_limit | input | 1 | An error counter is at or above the warning limit |
| st_bus_off | input | 1 | Engine is off the bus |
| st_partial | input | 1 | Current received frame is incomplete |
| ev_tx_done | input | 1 | Pulse: transmission finished |
| ev_rx_frame | input | 1 | Pulse: frame received |
| ev_err_warn | input | 1 | Pulse: error-warning state changed |
| ev_overrun | input | 1 | Pulse: receive storage overran |
| ev_err_passive | input | 1 | Pulse: error-passive state changed |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_err | input | 1 | Pulse: bus error detected |
| mode_reset | output | 1 | Controller held in reset mode |
| mode_listen | output | 1 | Listen-only mode |
| mode_selftest | output | 1 | Self-test mode |
| mode_single_filter | output | 1 | Single acceptance filter selected |
| mode_sleep | output | 1 | Sleep request |
| cmd_tx_req | output | 1 | Strobe: start transmission |
| cmd_tx_abort | output | 1 | Strobe: abort pending transmission |
| cmd_rx_release | output | 1 | Strobe: release receive buffer |
| cmd_clr_overrun | output | 1 | Strobe: overrun flag cleared |
| cmd_self_rx | output | 1 | Strobe: transmit with self-reception |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets the collision cases. In one, an event arrives in the same cycle as a cause read; a design that clears before it merges would silently lose that cause. In another, an overrun clear command coincides with a fresh overrun; clear-wins logic would drop the flag. The receive cause is read repeatedly with frames still queued. A design that cleared it would let the host believe the queue was drained. Transmit and self-receive commands are issued in reset mode, which a missing gate would pass to the engine. The enable register is narrowed under a pending cause to show whether `irq` drops at once or lags a cycle.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  // register offsets (host-visible decode)
  localparam int unsigned OFS_MODE = 0;
  localparam int unsigned OFS_CMD  = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_RAW  = 3;
  localparam int unsigned OFS_IEN  = 4;

  // mode register
  localparam int unsigned MODE_W      = 5;
  localparam int unsigned MB_RESET    = 0;
  localparam int unsigned MB_LISTEN   = 1;
  localparam int unsigned MB_SELFTEST = 2;
  localparam int unsigned MB_FILTER   = 3;
  localparam int unsigned MB_SLEEP    = 4;
  localparam logic [MODE_W-1:0] MODE_RST = 5'b00001;

  // command strobes
  localparam int unsigned CMD_W      = 5;
  localparam int unsigned CB_TX      = 0;
  localparam int unsigned CB_ABORT   = 1;
  localparam int unsigned CB_RELEASE = 2;
  localparam int unsigned CB_CLROVR  = 3;
  localparam int unsigned CB_SELFRX  = 4;
  // commands refused while the reset-mode bit is set
  localparam logic [CMD_W-1:0] CMD_NEED_OPER = 5'b10001;

  // cause / enable layout
  localparam int unsigned IRQ_W      = 8;
  localparam int unsigned IB_RX      = 0;
  localparam int unsigned IB_TX      = 1;
  localparam int unsigned IB_WARN    = 2;
  localparam int unsigned IB_OVR     = 3;
  localparam int unsigned IB_SPARE   = 4;
  localparam int unsigned IB_PASSIVE = 5;
  localparam int unsigned IB_ARB     = 6;
  localparam int unsigned IB_BUSERR  = 7;

  // status word
  localparam int unsigned STAT_W = 9;
endpackage

// File: rtl/canctl_mode_cmd.sv
module canctl_mode_cmd
  import canctl_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_VAL = MODE_RST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic              cmd_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CMD_W-1:0]  cmd_q
);

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= RST_VAL;
    else if (mode_we) mode_q <= mode_wdata;
  end

  // one flop per strobe; bits flagged in CMD_NEED_OPER are blocked in reset mode
  for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
    logic blocked;
    assign blocked = CMD_NEED_OPER[i] & mode_q[MB_RESET];
    always_ff @(posedge clk) begin
      if (rst) cmd_q[i] <= 1'b0;
      else     cmd_q[i] <= cmd_we & cmd_wdata[i] & ~blocked;
    end
  end

  // R3: without a command write the strobes are low on the next cycle
  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> (cmd_q == '0));

  // R4: transmit and self-receive never strobe from a write made in reset mode
  assert_cmd_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && mode_q[MB_RESET]) |=> (!cmd_q[CB_TX] && !cmd_q[CB_SELFRX]));

endmodule

// File: rtl/canctl_status.sv
module canctl_status
  import canctl_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_buf_free,
  input  logic              tx_done_flag,
  input  logic              receiving,
  input  logic              transmitting,
  input  logic              err_limit,
  input  logic              bus_off,
  input  logic              partial,
  input  logic              ovr_event,
  input  logic              ovr_clear,
  output logic              rx_pending,
  output logic [STAT_W-1:0] stat_word
);

  logic ovr_q;

  // the sticky flag: a new overrun beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)            ovr_q <= 1'b0;
    else if (ovr_event) ovr_q <= 1'b1;
    else if (ovr_clear) ovr_q <= 1'b0;
  end

  assign rx_pending = |rx_count;

  assign stat_word = {partial, bus_off, err_limit, transmitting, receiving,
                      tx_done_flag, tx_buf_free, ovr_q, rx_pending};

  // R6: an overrun always leaves the flag set
  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (rst)
    ovr_event |=> stat_word[1]);

  // R6: a lone clear drops it
  assert_ovr_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (ovr_clear && !ovr_event) |=> !stat_word[1]);

endmodule

// File: rtl/canctl_irq.sv
module canctl_irq
  import canctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] ev,
  input  logic             rx_pending,
  input  logic             raw_rd,
  input  logic             en_we,
  input  logic [IRQ_W-1:0] en_wdata,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] en_q,
  output logic             irq_q
);

  logic [IRQ_W-1:0] raw_d;
  logic [IRQ_W-1:0] en_d;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_cause
    if (i == IB_SPARE) begin : g_spare
      assign raw_d[i] = 1'b0;
      assign en_d[i]  = 1'b0;
    end else if (i == IB_RX) begin : g_rx
      // receive cause survives a read while frames are still queued
      assign raw_d[i] = ev[i] | (raw_q[i] & (~raw_rd | rx_pending));
      assign en_d[i]  = en_we ? en_wdata[i] : en_q[i];
    end else begin : g_evt
      assign raw_d[i] = ev[i] | (raw_q[i] & ~raw_rd);
      assign en_d[i]  = en_we ? en_wdata[i] : en_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      irq_q <= |(raw_d & en_d);
    end
  end

  // R10: the line always agrees with the registered cause and enable
  assert_irq_match_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(raw_q & en_q));

  // R8: receive cause held across a read while frames remain
  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_rd && rx_pending && raw_q[IB_RX]) |=> raw_q[IB_RX]);

  // R8: an event coinciding with a read is not lost
  assert_ev_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_rd && ev[IB_BUSERR]) |=> raw_q[IB_BUSERR]);

  // R8: a quiet read empties the register
  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (raw_rd && (ev == '0) && !rx_pending) |=> (raw_q == '0));

endmodule

// File: rtl/canctl_csr.sv
module canctl_csr
  import canctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned RD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  input  logic [CNT_W-1:0]  rx_msg_count,
  input  logic              st_tx_buf_free,
  input  logic              st_tx_done_flag,
  input  logic              st_receiving,
  input  logic              st_transmitting,
  input  logic              st_err_limit,
  input  logic              st_bus_off,
  input  logic              st_partial,
  input  logic              ev_tx_done,
  input  logic              ev_rx_frame,
  input  logic              ev_err_warn,
  input  logic              ev_overrun,
  input  logic              ev_err_passive,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  output logic              mode_reset,
  output logic              mode_listen,
  output logic              mode_selftest,
  output logic              mode_single_filter,
  output logic              mode_sleep,
  output logic              cmd_tx_req,
  output logic              cmd_tx_abort,
  output logic              cmd_rx_release,
  output logic              cmd_clr_overrun,
  output logic              cmd_self_rx,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);

  logic              mode_we, cmd_we, en_we, raw_rd;
  logic [MODE_W-1:0] mode_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_word;
  logic              rx_pending;
  logic [IRQ_W-1:0]  ev_vec, raw_q, en_q;

  assign mode_we = bus_wr && (bus_addr == A_MODE);
  assign cmd_we  = bus_wr && (bus_addr == A_CMD);
  assign en_we   = bus_wr && (bus_addr == A_IEN);
  assign raw_rd  = bus_rd && (bus_addr == A_RAW);

  always_comb begin
    ev_vec             = '0;
    ev_vec[IB_RX]      = ev_rx_frame;
    ev_vec[IB_TX]      = ev_tx_done;
    ev_vec[IB_WARN]    = ev_err_warn;
    ev_vec[IB_OVR]     = ev_overrun;
    ev_vec[IB_PASSIVE] = ev_err_passive;
    ev_vec[IB_ARB]     = ev_arb_lost;
    ev_vec[IB_BUSERR]  = ev_bus_err;
  end

  canctl_mode_cmd u_mode_cmd (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .cmd_we     (cmd_we),
    .mode_wdata (bus_wdata[MODE_W-1:0]),
    .cmd_wdata  (bus_wdata[CMD_W-1:0]),
    .mode_q     (mode_q),
    .cmd_q      (cmd_q)
  );

  canctl_status #(.CNT_W(CNT_W)) u_status (
    .clk          (clk),
    .rst          (rst),
    .rx_count     (rx_msg_count),
    .tx_buf_free  (st_tx_buf_free),
    .tx_done_flag (st_tx_done_flag),
    .receiving    (st_receiving),
    .transmitting (st_transmitting),
    .err_limit    (st_err_limit),
    .bus_off      (st_bus_off),
    .partial      (st_partial),
    .ovr_event    (ev_overrun),
    .ovr_clear    (cmd_we & bus_wdata[CB_CLROVR]),
    .rx_pending   (rx_pending),
    .stat_word    (stat_word)
  );

  canctl_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev_vec),
    .rx_pending (rx_pending),
    .raw_rd     (raw_rd),
    .en_we      (en_we),
    .en_wdata   (bus_wdata),
    .raw_q      (raw_q),
    .en_q       (en_q),
    .irq_q      (irq)
  );

  // registered read port; the cause register returns its pre-clear value
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_MODE:  bus_rdata <= RD_W'(mode_q);
        A_STAT:  bus_rdata <= RD_W'(stat_word);
        A_RAW:   bus_rdata <= RD_W'(raw_q);
        A_IEN:   bus_rdata <= RD_W'(en_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign mode_reset         = mode_q[MB_RESET];
  assign mode_listen        = mode_q[MB_LISTEN];
  assign mode_selftest      = mode_q[MB_SELFTEST];
  assign mode_single_filter = mode_q[MB_FILTER];
  assign mode_sleep         = mode_q[MB_SLEEP];

  assign cmd_tx_req      = cmd_q[CB_TX];
  assign cmd_tx_abort    = cmd_q[CB_ABORT];
  assign cmd_rx_release  = cmd_q[CB_RELEASE];
  assign cmd_clr_overrun = cmd_q[CB_CLROVR];
  assign cmd_self_rx     = cmd_q[CB_SELFRX];

  // R2: a mode write is visible on the outputs one cycle later
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (mode_sleep == $past(bus_wdata[MB_SLEEP]) &&
                 mode_reset == $past(bus_wdata[MB_RESET])));

endmodule

// File: tb/canctl_csr_tb.sv
module canctl_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0]  rx_msg_count = '0;
  logic st_tx_buf_free = 0, st_tx_done_flag = 0, st_receiving = 0, st_transmitting = 0;
  logic st_err_limit = 0, st_bus_off = 0, st_partial = 0;
  logic [7:0]  evm = '0;
  logic mode_reset, mode_listen, mode_selftest, mode_single_filter, mode_sleep;
  logic cmd_tx_req, cmd_tx_abort, cmd_rx_release, cmd_clr_overrun, cmd_self_rx;
  logic irq;

  always #10 clk = ~clk;  // 50 MHz

  canctl_csr dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_msg_count(rx_msg_count),
    .st_tx_buf_free(st_tx_buf_free), .st_tx_done_flag(st_tx_done_flag),
    .st_receiving(st_receiving), .st_transmitting(st_transmitting),
    .st_err_limit(st_err_limit), .st_bus_off(st_bus_off), .st_partial(st_partial),
    .ev_tx_done(evm[1]), .ev_rx_frame(evm[0]), .ev_err_warn(evm[2]),
    .ev_overrun(evm[3]), .ev_err_passive(evm[5]), .ev_arb_lost(evm[6]),
    .ev_bus_err(evm[7]),
    .mode_reset(mode_reset), .mode_listen(mode_listen), .mode_selftest(mode_selftest),
    .mode_single_filter(mode_single_filter), .mode_sleep(mode_sleep),
    .cmd_tx_req(cmd_tx_req), .cmd_tx_abort(cmd_tx_abort), .cmd_rx_release(cmd_rx_release),
    .cmd_clr_overrun(cmd_clr_overrun), .cmd_self_rx(cmd_self_rx), .irq(irq)
  );

  typedef struct { logic [15:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  logic rd_seen = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 16'h1, 16'h0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, bus_rdata, e.val);
      end
    end
  end

  // driver: one bus cycle, optional event mask in the same cycle
  task automatic bus_cycle(logic wr, logic rd, logic [4:0] a, logic [7:0] d,
                           logic [7:0] ev, logic [15:0] exp, string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evm = ev;
    if (rd) begin
      exp_t e;
      e.val = exp; e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; evm = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    bus_cycle(1, 0, a, d, 8'h00, 16'h0, "");
  endtask
  task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
    bus_cycle(0, 1, a, 8'h00, 8'h00, exp, tag);
  endtask
  task automatic fire(logic [7:0] ev);
    bus_cycle(0, 0, 5'd0, 8'h00, ev, 16'h0, "");
  endtask
  function automatic logic [4:0] cmdv();
    return {cmd_self_rx, cmd_clr_overrun, cmd_rx_release, cmd_tx_abort, cmd_tx_req};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 strobes", {11'h0, cmdv()}, 16'h0);
    check("R1 mode_reset", {15'h0, mode_reset}, 16'h1);
    rd(5'h00, 16'h0001, "R1 mode");
    rd(5'h04, 16'h0000, "R1 enable");
    rd(5'h03, 16'h0000, "R1 cause");
    // R4: in reset mode only abort/release/clear strobe
    wr(5'h01, 8'h1F);
    check("R4 gated strobes", {11'h0, cmdv()}, 16'h000E);
    @(negedge clk);
    check("R3 strobe one cycle", {11'h0, cmdv()}, 16'h0);
    // R2 mode write
    wr(5'h00, 8'hE6);
    check("R2 mode outputs", {11'h0, mode_sleep, mode_single_filter, mode_selftest,
                              mode_listen, mode_reset}, 16'h0006);
    rd(5'h00, 16'h0006, "R2 mode readback");
    // R3 in operating mode every requested strobe fires
    wr(5'h01, 8'h11);
    check("R3 tx and selfrx strobes", {11'h0, cmdv()}, 16'h0011);
    @(negedge clk);
    check("R3 strobe cleared", {11'h0, cmdv()}, 16'h0);
    rd(5'h01, 16'h0000, "R3 command reads zero");
    // R5 status composition
    st_tx_buf_free = 1; st_tx_done_flag = 1;
    rd(5'h02, 16'h000C, "R5 status pattern A");
    st_tx_buf_free = 0; st_tx_done_flag = 0; rx_msg_count = 7'd3;
    st_receiving = 1; st_err_limit = 1; st_bus_off = 1; st_partial = 1;
    rd(5'h02, 16'h01D1, "R5 status pattern B");
    rx_msg_count = 0; st_receiving = 0; st_err_limit = 0; st_bus_off = 0; st_partial = 0;
    // R6 sticky overrun
    fire(8'h08);
    rd(5'h02, 16'h0002, "R6 overrun set");
    bus_cycle(1, 0, 5'h01, 8'h08, 8'h08, 16'h0, "");
    rd(5'h02, 16'h0002, "R6 event beats clear");
    wr(5'h01, 8'h08);
    rd(5'h02, 16'h0000, "R6 clear");
    check("R10 masked cause", {15'h0, irq}, 16'h0);
    rd(5'h03, 16'h0008, "R7 overrun cause");
    // R7/R8 latch and clear
    fire(8'h42);
    rd(5'h03, 16'h0042, "R7 tx and arb causes");
    rd(5'h03, 16'h0000, "R8 cleared by read");
    rx_msg_count = 7'd2;
    fire(8'h01);
    rd(5'h03, 16'h0001, "R8 rx cause");
    rd(5'h03, 16'h0001, "R8 rx held while queued");
    rx_msg_count = 0;
    rd(5'h03, 16'h0001, "R8 rx still latched");
    rd(5'h03, 16'h0000, "R8 rx cleared when empty");
    bus_cycle(0, 1, 5'h03, 8'h00, 8'h80, 16'h0000, "R8 read with event");
    rd(5'h03, 16'h0080, "R8 coinciding event kept");
    fire(8'hFF);
    rd(5'h03, 16'h00EF, "R7 all causes bit4 zero");
    rd(5'h03, 16'h0000, "R8 all cleared");
    // R9/R10 enable and line
    wr(5'h04, 8'hFF);
    rd(5'h04, 16'h00EF, "R9 enable bit4 dropped");
    check("R10 no cause no irq", {15'h0, irq}, 16'h0);
    fire(8'h08);
    check("R10 irq raised", {15'h0, irq}, 16'h1);
    wr(5'h04, 8'hE7);
    check("R10 mask takes effect next clock", {15'h0, irq}, 16'h0);
    wr(5'h04, 8'hFF);
    check("R10 unmask raises irq", {15'h0, irq}, 16'h1);
    rd(5'h03, 16'h0008, "R8 cause before clear");
    check("R10 irq drops after read", {15'h0, irq}, 16'h0);
    wr(5'h04, 8'hE7);
    fire(8'h04);
    check("R10 warn irq", {15'h0, irq}, 16'h1);
    rd(5'h03, 16'h0004, "R7 warn cause");
    check("R10 warn irq cleared", {15'h0, irq}, 16'h0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule